// File: doc/BRIEF.md
# HDLC Receive Frame Engine

This block is the bit-level front end of an HDLC receiver. It takes a serial line bit together with a strobe that marks each valid bit. It finds flags and aborts, deletes the zeros the transmitter inserted, and builds bytes from the bits, least significant bit first. It also runs the 16-bit frame check over every frame. The two bytes just before the closing flag carry the frame check field, so they never reach the output. Address, control and information bytes leave one per strobe on a simple valid/data/tag port that feeds a receive FIFO. Each byte carries a two-bit tag that marks it as the start of a packet, an ordinary byte, or the final byte of a good or bad packet.

The engine keeps three assembled bytes in reserve. A byte is released only once three more have arrived behind it, so the frame check bytes are never sent as data. When the closing flag arrives, the oldest reserved byte goes out as the last byte of the packet, with a good or bad tag. A frame that ends before any byte has been released produces no output. On every closing flag, the received check field is copied into an output register exactly as it came off the line. The receiver enable takes effect at once. A disable waits until the current packet has been completely delivered, unless none of its bytes has gone out yet.

Top module: `hdlc_rx_engine`

## Requirements
- R1: A flag is the bit pattern 01111110. A zero that follows five consecutive ones inside a frame is deleted, so payload bytes such as 0x7E and 0xFF come out unchanged.
- R2: The last 16 bits before a closing flag are never output. Only the bytes in front of them are delivered, in arrival order, each assembled with the first-received bit in bit 0.
- R3: Tag encoding: 2'b01 marks the first byte of a packet and 2'b00 marks a byte in the middle. Every packet starts with exactly one 2'b01 byte.
- R4: The last byte of a frame is tagged 2'b10 when the frame check residue is 0xF0B8, using the CRC-16-CCITT polynomial in LSB-first form preset to 0xFFFF. It is tagged 2'b11 when the residue differs. No byte follows an end-tagged byte in the next cycle.
- R5: Seven consecutive ones abort the frame. If bytes of that frame were already output, the oldest reserved byte is output tagged 2'b11. The receiver then waits for a flag.
- R6: A frame with fewer than 32 bits between its flags (fewer than four bytes) outputs nothing.
- R7: A frame whose bit count between flags is not a multiple of 8 ends with its last output byte tagged 2'b11.
- R8: When enabled while a packet is in progress, the receiver ignores that packet and delivers the next complete one. The enable needs no settling time.
- R9: If rx_en falls after a byte of the current packet has been output, the rest of that packet is still delivered, ending with its last-byte tag. Later packets are ignored while rx_en stays low.
- R10: If rx_en falls before any byte of the current packet has been output, no byte of that packet or of any later packet is output while rx_en stays low.
- R11: On each closing flag, crc_capture loads the last 16 bits received before that flag. The first of those bits goes to bit 15, and the bits keep their line polarity (inverted). crc_capture does not change at any other time, including on an abort.
- R12: After reset, out_valid is 0 and crc_capture is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| bit_valid | input | 1 | Strobe marking bit_in as a line bit |
| bit_in | input | 1 | Serial line bit |
| out_valid | output | 1 | One-cycle pulse, a byte is on out_data |
| out_data | output | 8 | Received byte |
| out_tag | output | 2 | Byte tag: 01 first, 00 middle, 10 last good, 11 last bad |
| crc_capture | output | 16 | Frame check field of the latest closed frame |

## Verification
The bench sends frames whose payloads force zero insertion around 0x7E and 0xFF. If destuffing or flag detection were wrong, corrupted bytes or split frames would reach the queue compare. It sends a minimum four-byte frame, a three-byte frame, a frame with three extra bits and a frame with a corrupted check field. A design with a wrong hold-back depth would leak check bytes or lose the last payload byte, and one with a wrong length or residue test would tag the ends wrongly. It aborts a frame in mid-payload and checks the exact bad-tagged byte. It confirms that the abort leaves crc_capture unchanged, since a design that captured on abort would overwrite it. It moves rx_en in the middle of a packet before and after the first byte is released, and raises it in the middle of a packet. A design that applied the disable at once, or that did not wait for a flag, would cut packets short or deliver fragments. Back-to-back frames that share one flag check that a closing flag also opens the next frame.

// File: rtl/hdlc_rx_engine.sv
module hdlc_rx_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        bit_valid,
  input  logic        bit_in,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic [1:0]  out_tag,
  output logic [15:0] crc_capture
);

  localparam logic [7:0]  FLAG     = 8'h7E;
  localparam logic [15:0] POLY     = 16'h8408;
  localparam logic [15:0] PRESET   = 16'hFFFF;
  localparam logic [15:0] RESIDUE  = 16'hF0B8;
  localparam logic [1:0]  TAG_BODY = 2'b00;
  localparam logic [1:0]  TAG_HEAD = 2'b01;
  localparam logic [1:0]  TAG_GOOD = 2'b10;
  localparam logic [1:0]  TAG_BAD  = 2'b11;

  logic [7:0]  win;
  logic [3:0]  fill;
  logic        hunt;
  logic [2:0]  ones;
  logic [6:0]  sh;
  logic [2:0]  bc;
  logic [15:0] crc, fcs_sh;
  logic [7:0]  h0, h1, h2;
  logic [1:0]  hc;
  logic        sent_any, inframe, close_pend, abort_pend;

  wire        live      = rx_en | sent_any;
  wire        stb       = live & bit_valid;
  wire [7:0]  win_n     = {win[6:0], bit_in};
  wire        flag_hit  = stb && fill >= 4'd7 && win_n == FLAG;
  wire        abort_hit = stb && fill >= 4'd6 && win_n[6:0] == 7'h7F;
  wire        d         = win[7];
  wire        out_bit   = stb && fill == 4'd8 && !hunt;
  wire        stuffed   = out_bit && !d && ones == 3'd5;
  wire        acc       = out_bit && !stuffed;
  wire [7:0]  byte_n    = {d, sh};
  wire        byte_done = acc && bc == 3'd7;
  wire        fb        = crc[0] ^ d;
  wire [15:0] crc_n     = (crc >> 1) ^ (fb ? POLY : 16'h0000);
  wire        frame_ok  = bc == 3'd0 && crc == RESIDUE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0; fill <= '0; hunt <= 1'b1; ones <= '0; sh <= '0; bc <= '0;
      crc <= PRESET; fcs_sh <= '0; h0 <= '0; h1 <= '0; h2 <= '0; hc <= '0;
      sent_any <= 1'b0; inframe <= 1'b0; close_pend <= 1'b0; abort_pend <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_tag <= '0; crc_capture <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!live) begin
        fill <= '0; hunt <= 1'b1; ones <= '0; bc <= '0; hc <= '0; crc <= PRESET;
        inframe <= 1'b0; close_pend <= 1'b0; abort_pend <= 1'b0;
      end else begin
        if (close_pend || abort_pend) begin
          if (sent_any) begin
            out_valid <= 1'b1;
            out_data  <= h0;
            out_tag   <= (close_pend && frame_ok) ? TAG_GOOD : TAG_BAD;
          end
          if (close_pend) crc_capture <= fcs_sh;
          ones <= '0; bc <= '0; hc <= '0; crc <= PRESET;
          sent_any <= 1'b0; inframe <= 1'b0;
          close_pend <= 1'b0; abort_pend <= 1'b0;
        end
        if (stb) begin
          win <= win_n;
          if (flag_hit) begin
            fill <= '0;
            hunt <= 1'b0;
            if (!hunt && (inframe || acc)) close_pend <= 1'b1;
          end else if (abort_hit) begin
            fill <= '0;
            hunt <= 1'b1;
            if (!hunt && (inframe || acc)) abort_pend <= 1'b1;
          end else if (fill != 4'd8) begin
            fill <= fill + 4'd1;
          end
        end
        if (out_bit) begin
          ones <= d ? ((ones == 3'd5) ? ones : ones + 3'd1) : 3'd0;
          if (acc) begin
            crc     <= crc_n;
            fcs_sh  <= {fcs_sh[14:0], d};
            sh      <= byte_n[7:1];
            bc      <= bc + 3'd1;
            inframe <= 1'b1;
            if (byte_done) begin
              if (hc != 2'd3) begin
                if (hc == 2'd0)      h0 <= byte_n;
                else if (hc == 2'd1) h1 <= byte_n;
                else                 h2 <= byte_n;
                hc <= hc + 2'd1;
              end else begin
                out_valid <= 1'b1;
                out_data  <= h0;
                out_tag   <= sent_any ? TAG_BODY : TAG_HEAD;
                h0 <= h1; h1 <= h2; h2 <= byte_n;
                sent_any <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  logic in_pkt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_pkt_q <= 1'b0;
    else if (out_valid) in_pkt_q <= !out_tag[1];
  end

  assert_body_in_packet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag == TAG_BODY) |-> in_pkt_q);
  assert_head_outside_packet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag == TAG_HEAD) |-> !in_pkt_q);
  assert_end_then_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag[1]) |=> !out_valid);
  assert_three_withheld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sent_any |-> hc == 2'd3);
  assert_abort_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pend && sent_any) |=> (out_valid && out_tag == TAG_BAD));
  assert_capture_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !close_pend |=> $stable(crc_capture));
  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !sent_any) |=> !out_valid);

endmodule

// File: tb/test_hdlc_rx_engine.sv
module test_hdlc_rx_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] T_BODY = 2'b00, T_HEAD = 2'b01, T_GOOD = 2'b10, T_BAD = 2'b11;

  logic clk = 1'b0;
  logic rst_n, rx_en, bit_valid, bit_in;
  logic out_valid;
  logic [7:0] out_data;
  logic [1:0] out_tag;
  logic [15:0] crc_capture;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_engine i_hdlc_rx_engine (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_valid(bit_valid), .bit_in(bit_in),
    .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag), .crc_capture(crc_capture)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] q_data[$];
  logic [1:0] q_tag[$];
  string      q_req[$];

  logic [7:0]  pl[0:15];
  int          tx_ones = 0, gap_ctr = 0;
  logic [15:0] tx_crc, last_fcs;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic f;
    f = c[0] ^ b;
    return (c >> 1) ^ (f ? 16'h8408 : 16'h0000);
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] x);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[15-i] = x[i];
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R2 unexpected byte", {22'd0, out_tag, out_data}, 32'h0);
      end else begin
        logic [7:0] ed;
        logic [1:0] et;
        string rq;
        ed = q_data.pop_front(); et = q_tag.pop_front(); rq = q_req.pop_front();
        check(out_data == ed && out_tag == et, rq, {22'd0, out_tag, out_data}, {22'd0, et, ed});
      end
    end
  end

  task automatic push(input logic [7:0] dv, input logic [1:0] tv, input string rq);
    q_data.push_back(dv); q_tag.push_back(tv); q_req.push_back(rq);
  endtask

  task automatic push_frame(input int n, input logic [1:0] last_tag, input string rq);
    for (int i = 0; i < n; i++)
      push(pl[i], (i == 0) ? T_HEAD : ((i == n-1) ? last_tag : T_BODY), rq);
  endtask

  task automatic send_raw(input logic b);
    if (gap_ctr % 7 == 6) begin
      bit_valid = 1'b0;
      @(negedge clk);
    end
    gap_ctr++;
    bit_in = b; bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    send_raw(b);
    tx_crc = crc_step(tx_crc, b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_raw(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_flag();
    send_raw(1'b0);
    for (int i = 0; i < 6; i++) send_raw(1'b1);
    send_raw(1'b0);
    tx_ones = 0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) send_flag();
  endtask

  task automatic tx_frame(input int n, input bit corrupt, input int extra,
                          input int en_at, input int dis_at, input bit skip_open);
    logic [15:0] f;
    tx_crc = 16'hFFFF;
    if (!skip_open) send_flag();
    for (int i = 0; i < n; i++) begin
      if (i == en_at) rx_en = 1'b1;
      if (i == dis_at) rx_en = 1'b0;
      for (int j = 0; j < 8; j++) send_bit(pl[i][j]);
    end
    for (int i = 0; i < extra; i++) send_bit(1'b0);
    f = ~tx_crc;
    if (corrupt) f[3] = ~f[3];
    for (int i = 0; i < 16; i++) send_bit(f[i]);
    send_flag();
    last_fcs = f;
  endtask

  task automatic chk_empty(input string rq);
    check(q_data.size() == 0, rq, q_data.size(), 0);
    q_data.delete(); q_tag.delete(); q_req.delete();
  endtask

  initial begin
    logic [15:0] cap_keep;
    rst_n = 1'b0; rx_en = 1'b1; bit_valid = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R12 out_valid", out_valid, 0);
    check(crc_capture == 16'h0, "R12 crc_capture", crc_capture, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && crc_capture == 16'h0, "R12 after release", crc_capture, 0);
    idle(2);

    // R2 R3 R4: minimum frame
    pl[0] = 8'hA1; pl[1] = 8'h03;
    push_frame(2, T_GOOD, "R4 min frame");
    tx_frame(2, 0, 0, -1, -1, 0); idle(2);
    chk_empty("R2 min frame drained");
    check(crc_capture == rev16(last_fcs), "R11 capture good", crc_capture, rev16(last_fcs));

    // R1: stuffing-heavy payload
    pl[0] = 8'h7E; pl[1] = 8'hFF; pl[2] = 8'h3F; pl[3] = 8'hFC; pl[4] = 8'h1F; pl[5] = 8'hF8;
    push_frame(6, T_GOOD, "R1 stuffed payload");
    tx_frame(6, 0, 0, -1, -1, 0); idle(2);
    chk_empty("R1 stuffed drained");

    // R4: bad check field
    pl[0] = 8'h10; pl[1] = 8'h20; pl[2] = 8'h30; pl[3] = 8'h40; pl[4] = 8'h50;
    push_frame(5, T_BAD, "R4 bad fcs");
    tx_frame(5, 1, 0, -1, -1, 0); idle(2);
    chk_empty("R4 bad drained");
    check(crc_capture == rev16(last_fcs), "R11 capture bad", crc_capture, rev16(last_fcs));

    // R6: short frame
    pl[0] = 8'h55;
    tx_frame(1, 0, 0, -1, -1, 0); idle(2);
    chk_empty("R6 short frame silent");
    check(crc_capture == rev16(last_fcs), "R11 capture short", crc_capture, rev16(last_fcs));

    // R7: non-octet frame
    pl[0] = 8'h01; pl[1] = 8'h02; pl[2] = 8'h04;
    push_frame(3, T_BAD, "R7 non-octet");
    tx_frame(3, 0, 3, -1, -1, 0); idle(2);
    chk_empty("R7 drained");

    // R5: abort mid-payload
    cap_keep = crc_capture;
    pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33; pl[3] = 8'h44; pl[4] = 8'h55; pl[5] = 8'h66;
    push(8'h11, T_HEAD, "R5 abort"); push(8'h22, T_BODY, "R5 abort"); push(8'h33, T_BAD, "R5 abort");
    send_flag();
    for (int i = 0; i < 6; i++) for (int j = 0; j < 8; j++) send_bit(pl[i][j]);
    for (int i = 0; i < 8; i++) send_raw(1'b1);
    tx_ones = 0;
    idle(3);
    chk_empty("R5 abort drained");
    check(crc_capture == cap_keep, "R11 abort keeps capture", crc_capture, cap_keep);

    // R8: enable while a packet runs
    rx_en = 1'b0; idle(2);
    pl[0] = 8'hC1; pl[1] = 8'hC2; pl[2] = 8'hC3; pl[3] = 8'hC4; pl[4] = 8'hC5;
    tx_frame(5, 0, 0, 2, -1, 0); idle(2);
    chk_empty("R8 partial packet ignored");
    pl[0] = 8'hD1; pl[1] = 8'hD2; pl[2] = 8'hD3;
    push_frame(3, T_GOOD, "R8 next packet");
    tx_frame(3, 0, 0, -1, -1, 0); idle(2);
    chk_empty("R8 drained");

    // R9: deferred disable
    for (int i = 0; i < 8; i++) pl[i] = 8'h21 + 8'(i);
    push_frame(8, T_GOOD, "R9 deferred disable");
    tx_frame(8, 0, 0, -1, 6, 0); idle(2);
    chk_empty("R9 full packet delivered");
    pl[0] = 8'hE1; pl[1] = 8'hE2; pl[2] = 8'hE3; pl[3] = 8'hE4;
    tx_frame(4, 0, 0, -1, -1, 0); idle(2);
    chk_empty("R9 later packet ignored");

    // R10: disable before any byte out
    rx_en = 1'b1; idle(2);
    pl[0] = 8'h61; pl[1] = 8'h62; pl[2] = 8'h63; pl[3] = 8'h64; pl[4] = 8'h65;
    tx_frame(5, 0, 0, -1, 1, 0); idle(2);
    tx_frame(5, 0, 0, -1, -1, 0); idle(2);
    chk_empty("R10 nothing while disabled");
    rx_en = 1'b1; idle(2);
    pl[0] = 8'h71; pl[1] = 8'h72; pl[2] = 8'h73; pl[3] = 8'h74;
    push_frame(4, T_GOOD, "R10 re-enabled");
    tx_frame(4, 0, 0, -1, -1, 0); idle(2);
    chk_empty("R10 drained");

    // R1 R11: frames sharing one flag
    pl[0] = 8'h81; pl[1] = 8'h82;
    push_frame(2, T_GOOD, "R1 shared flag first");
    tx_frame(2, 0, 0, -1, -1, 0);
    pl[0] = 8'h91; pl[1] = 8'h92; pl[2] = 8'h93;
    push_frame(3, T_GOOD, "R1 shared flag second");
    tx_frame(3, 0, 0, -1, -1, 1); idle(2);
    chk_empty("R1 shared flag drained");
    check(crc_capture == rev16(last_fcs), "R11 capture shared", crc_capture, rev16(last_fcs));

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule